// File: doc/BRIEF.md
# RGMII Transmit Double-Data-Rate Adapter

This block takes a byte-wide transmit stream (one data byte, a valid flag and an error flag, all sampled on the rising edge of a single-rate transmit clock). It drives the reduced-pin gigabit form of that stream. Each byte leaves on a 4-bit bus as two nibbles, one per clock half. The valid and error flags share one control pin, which also changes on both clock halves. A copy of the transmit clock goes out with the data, at the same frequency.

Both halves of a byte are registered together on the rising edge (same-edge capture). The upper half is then retimed onto a falling-edge flop, so the second half of a period never sees a byte that changes mid-period. Link speed is set only by the clock the block runs on: 125 MHz for gigabit, 25 MHz for 100 Mbps and 2.5 MHz for 10 Mbps. The byte-to-pin mapping is the same at every speed. The output double-data-rate stages are plain rising and falling flops with a clock-phase select. No library cells are used.

Top module: `rgmii_tx_ddr`

## Requirements
- R1: A byte sampled at rising edge k appears on `pin_d` during the high phase that follows edge k, as its bits 3:0. The fixed latency is one clock period, so that byte is not visible before edge k.
- R2: During the low phase after edge k, `pin_d` carries bits 7:4 of the byte sampled at edge k.
- R3: During the high phase after edge k, `pin_ctl` equals the `byte_valid` sampled at edge k.
- R4: During the low phase after edge k, `pin_ctl` equals `byte_valid` XOR `byte_err` as sampled at edge k. For example, valid=1 with err=0 gives 1 then 1, valid=1 with err=1 gives 1 then 0, and valid=0 with err=1 gives 0 then 1.
- R5: A change on the byte inputs after edge k and before edge k+1 has no effect on the low-phase nibble or the low-phase control value of period k.
- R6: Outside reset, `pin_clk` is high during the high phase of `clk` and low during the low phase, at the same frequency as `clk`.
- R7: While `rst_n` is low, `pin_d`, `pin_ctl` and `pin_clk` are all 0, whatever the inputs are. Reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-rate transmit clock; its rate selects the link speed |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_in | input | 8 | Byte to transmit |
| byte_valid | input | 1 | Byte is part of a frame |
| byte_err | input | 1 | Byte carries an error indication |
| pin_d | output | 4 | Double-data-rate data nibble |
| pin_ctl | output | 1 | Double-data-rate control line |
| pin_clk | output | 1 | Forwarded transmit clock |

## Verification
A wrong capture register shows up on the high-phase pins during the period right after the bad edge. A wrong or missing falling-edge retiming stage shows up as a wrong low-phase nibble or control value in that same period. It can also show as the following byte leaking in when the inputs change mid-period. The bench therefore samples each pin in both phases of every period. It also changes the inputs during the high phase, so that a fault in the hold path appears within half a clock period.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;
    parameter int NIB_W = 4;

    typedef struct packed {
        logic [NIB_W-1:0] lo;    // first-half nibble
        logic [NIB_W-1:0] hi;    // second-half nibble
        logic             c_lo;  // first-half control
        logic             c_hi;  // second-half control
        logic             live;  // set from the first edge after reset
    } tx_pair_t;
endpackage

// File: rtl/rgmii_tx_capture.sv
module rgmii_tx_capture
    import rgmii_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NIB_W-1:0] byte_in,
    input  logic               byte_valid,
    input  logic               byte_err,
    output tx_pair_t           pair_q
);
    tx_pair_t pair_d;

    // Same-edge capture: both halves of the byte are taken on the rising edge
    always_comb begin
        pair_d      = pair_q;
        pair_d.lo   = byte_in[NIB_W-1:0];
        pair_d.hi   = byte_in[2*NIB_W-1:NIB_W];
        pair_d.c_lo = byte_valid;
        pair_d.c_hi = byte_valid ^ byte_err;
        pair_d.live = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end
endmodule

// File: rtl/rgmii_tx_ddr_lane.sv
module rgmii_tx_ddr_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_val,  // already registered on the rising edge
    input  logic fall_val,  // already registered on the rising edge
    output logic pin
);
    logic fall_d, fall_q;

    always_comb fall_d = fall_val;

    // Retime the second half onto the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
    end

    assign pin = clk ? rise_val : fall_q;
endmodule

// File: rtl/rgmii_tx_ddr.sv
module rgmii_tx_ddr
    import rgmii_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NIB_W-1:0] byte_in,
    input  logic               byte_valid,
    input  logic               byte_err,
    output logic [NIB_W-1:0]   pin_d,
    output logic               pin_ctl,
    output logic               pin_clk
);
    localparam int LANES = NIB_W + 2;  // data lanes, control lane, clock lane

    tx_pair_t         pair_q;
    logic [LANES-1:0] rise_v, fall_v, pins;

    rgmii_tx_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .byte_err   (byte_err),
        .pair_q     (pair_q)
    );

    // Lane map: [NIB_W-1:0] data, [NIB_W] control, [NIB_W+1] forwarded clock
    always_comb begin
        rise_v = {pair_q.live, pair_q.c_lo, pair_q.lo};
        fall_v = {1'b0,        pair_q.c_hi, pair_q.hi};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rgmii_tx_ddr_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_val (rise_v[g]),
            .fall_val (fall_v[g]),
            .pin      (pins[g])
        );
    end

    assign pin_d   = pins[NIB_W-1:0];
    assign pin_ctl = pins[NIB_W];
    assign pin_clk = pins[NIB_W+1];

    // High phase (sampled at the falling edge) shows the captured first half
    assert_first_nibble_R1: assert property (@(negedge clk) disable iff (!rst_n)
        pair_q.live |-> pin_d == pair_q.lo);
    assert_first_ctl_R3: assert property (@(negedge clk) disable iff (!rst_n)
        pair_q.live |-> pin_ctl == pair_q.c_lo);
    // Low phase (sampled at the next rising edge) shows the previous byte's upper half
    assert_second_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pair_q.live |-> pin_d == $past(byte_in[2*NIB_W-1:NIB_W]));
    assert_second_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_q.live |-> pin_ctl == ($past(byte_valid) ^ $past(byte_err)));
    assert_clk_phase_R6: assert property (@(negedge clk) disable iff (!rst_n)
        pair_q.live |-> pin_clk);
    assert_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_clk);
    assert_reset_quiet_R7: assert property (@(negedge clk)
        !rst_n |-> (pin_d == '0 && !pin_ctl && !pin_clk));
endmodule

// File: tb/rgmii_tx_ddr_tb_top.sv
module rgmii_tx_ddr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = 8'hFF;
    logic       byte_valid = 1'b1;
    logic       byte_err = 1'b1;
    logic [3:0] pin_d;
    logic       pin_ctl, pin_clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rgmii_tx_ddr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .byte_err   (byte_err),
        .pin_d      (pin_d),
        .pin_ctl    (pin_ctl),
        .pin_clk    (pin_clk)
    );

    // {byte, valid, err, exp lo nibble, exp hi nibble, exp ctl high, exp ctl low}
    localparam logic [19:0] VEC [8] = '{
        {8'hA5, 2'b10, 4'h5, 4'hA, 2'b11},
        {8'h3C, 2'b10, 4'hC, 4'h3, 2'b11},
        {8'hFF, 2'b11, 4'hF, 4'hF, 2'b10},
        {8'h00, 2'b00, 4'h0, 4'h0, 2'b00},
        {8'h0F, 2'b01, 4'hF, 4'h0, 2'b01},
        {8'hF0, 2'b10, 4'h0, 4'hF, 2'b11},
        {8'h96, 2'b11, 4'h6, 4'h9, 2'b10},
        {8'h5A, 2'b00, 4'hA, 4'h5, 2'b00}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [7:0] b, input logic v, input logic e);
        byte_in = b; byte_valid = v; byte_err = e;
    endtask

    initial begin
        // R7: reset holds every pin low, in both phases
        repeat (2) @(posedge clk);
        #5  chk("R7", "pin_d high phase", pin_d, 0);
            chk("R7", "pin_ctl high phase", pin_ctl, 0);
            chk("R7", "pin_clk high phase", pin_clk, 0);
        #10 chk("R7", "pin_d low phase", pin_d, 0);
            chk("R7", "pin_ctl low phase", pin_ctl, 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // Vector table walk: R1..R4, R6
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2 drive(VEC[i][19:12], VEC[i][11], VEC[i][10]);
            @(posedge clk);
            #5  chk("R1", "lo nibble", pin_d, VEC[i][9:6]);
                chk("R3", "ctl high", pin_ctl, VEC[i][1]);
                chk("R6", "clk high", pin_clk, 1);
            #10 chk("R2", "hi nibble", pin_d, VEC[i][5:2]);
                chk("R4", "ctl low", pin_ctl, VEC[i][0]);
                chk("R6", "clk low", pin_clk, 0);
        end

        // R1 latency: byte driven now is not visible before the next edge
        @(posedge clk); #2 drive(8'h12, 1'b1, 1'b0);
        #10 chk("R1", "no early nibble", pin_d, 4'h5);
        @(posedge clk);
        #5  chk("R1", "lo after one period", pin_d, 4'h2);
        // R5: change inputs mid-period; low phase keeps the held byte
        #2  drive(8'hEE, 1'b0, 1'b1);
        #8  chk("R5", "held hi nibble", pin_d, 4'h1);
            chk("R5", "held ctl low", pin_ctl, 1);
        @(posedge clk);
        #5  chk("R1", "next lo", pin_d, 4'hE);
            chk("R3", "next ctl high", pin_ctl, 0);
        #10 chk("R2", "next hi", pin_d, 4'hE);
            chk("R4", "err only ctl low", pin_ctl, 1);

        // R7: asynchronous reset mid-frame
        @(posedge clk); #2 drive(8'hFF, 1'b1, 1'b0);
        @(posedge clk); #2 rst_n = 1'b0;
        #1  chk("R7", "async pin_d", pin_d, 0);
            chk("R7", "async pin_ctl", pin_ctl, 0);
            chk("R7", "async pin_clk", pin_clk, 0);
        #10 chk("R7", "reset low-phase pin_d", pin_d, 0);
        @(posedge clk); #2 rst_n = 1'b1; drive(8'hC3, 1'b1, 1'b1);
        @(posedge clk);
        #5  chk("R1", "first byte after reset", pin_d, 4'h3);
            chk("R6", "clk resumes", pin_clk, 1);
        #10 chk("R2", "first hi after reset", pin_d, 4'hC);
            chk("R4", "first ctl low after reset", pin_ctl, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule